// File: doc/BRIEF.md
# Nonvolatile Shadow Store Controller

This block models a small memory made of a volatile SRAM array paired with a nonvolatile shadow array of the same size. Ordinary accesses are decoded from an active-low chip enable, an active-low write enable and an active-low output enable. A read drives the addressed word onto the data bus. A write updates the addressed word. While chip enable is inactive the block sits in standby and leaves the bus undriven.

An active-low hardware store strobe asks for the whole SRAM to be copied into the shadow array. It does so whatever the chip enable, write enable and address inputs are doing. The copy is made only if the SRAM has been written since the last nonvolatile operation. Once the copy finishes, or is skipped, the block refuses every access until the strobe returns high. A recall request copies the shadow array back into the SRAM. Both transfers move one word per clock, and a busy output stays high for the whole transfer and for the lock-out that follows.

The bus is modelled as a data output with a separate drive-enable output. The array depth is set by the `ADDR_W` parameter. The default of 8 gives 256 words; 13 gives the full 8K-word arrangement.

Top module: `nvs_shadow_ctrl`

## Requirements
- R1: While `ce_ni` is high, `data_oe_o` is low and a low `we_ni` does not change any SRAM word.
- R2: When idle with `hsb_ni` high, `ce_ni` low, `we_ni` high and `oe_ni` low, `data_oe_o` is high and `data_o` equals the word at `addr_i`, in the same cycle.
- R3: `oe_ni` only gates bus drive: a read with `oe_ni` high leaves `data_oe_o` low, and a store strobe starts no matter what `oe_ni` is.
- R4: When idle with `hsb_ni` high, `recall_i` low, `ce_ni` low and `we_ni` low, the clock edge writes `data_i` into the word at `addr_i`, and the block is marked as written.
- R5: When `hsb_ni` is sampled low while idle and written, `busy_o` rises at that edge and the SRAM is copied into the shadow array one word per clock for 2^ADDR_W cycles. If the strobe is already high again at the end of the copy, `busy_o` stays high for exactly 2^ADDR_W + 1 cycles.
- R6: When `hsb_ni` is sampled low while idle and not written, no copy takes place and the block goes straight to lock-out. `busy_o` then stays high for exactly as many cycles as `hsb_ni` is sampled low.
- R7: During a store, a recall or the lock-out, chip enable, write enable and address are ignored: no SRAM word changes and the bus is not driven.
- R8: The lock-out ends at the first clock edge that samples `hsb_ni` high, so `busy_o` is low in the following cycle.
- R9: A `recall_i` pulse sampled while idle with `hsb_ni` high copies the shadow array into the SRAM over 2^ADDR_W cycles with `busy_o` high, and leaves the block marked as not written.
- R10: After reset, `busy_o` and `data_oe_o` are low and the block is marked as not written.
- R11: The data bus is never driven while `busy_o` is high.
- R12: A completed store clears the written mark, so the next strobe with no write in between is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low; gates read drive only |
| hsb_ni | input | 1 | Hardware store strobe, active low |
| recall_i | input | 1 | Recall request, sampled while idle |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data, zero when not driven |
| data_oe_o | output | 1 | Bus drive enable |
| busy_o | output | 1 | High during a transfer and during lock-out |

## Verification
The hardest case to reach is the lock-out while hostile accesses are applied. Write strobes aimed at a word with known contents have to arrive during the copy and during the lock-out, and then be shown to have had no effect. The stimulus holds chip enable and write enable low with junk data for the whole time the strobe is low, and releases them in the same cycle the strobe rises. It then reads the target word back. The skipped-store path is reached only after a recall or a completed store has cleared the written mark. It is told apart from a real copy by the exact length of `busy_o`, which is compared each cycle against the reference model.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    NVS_IDLE   = 2'd0,
    NVS_STORE  = 2'd1,
    NVS_RECALL = 2'd2,
    NVS_LOCK   = 2'd3
  } nvs_state_e;
endpackage

// File: rtl/nvs_mode_decode.sv
module nvs_mode_decode (
  input  logic idle_i,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  input  logic hsb_ni,
  input  logic recall_i,
  output logic store_go_o,
  output logic recall_go_o,
  output logic acc_wr_o,
  output logic drive_o
);
  logic access_ok;

  // the store strobe wins over everything, recall wins over plain accesses
  assign access_ok   = idle_i & hsb_ni;
  assign store_go_o  = idle_i & ~hsb_ni;
  assign recall_go_o = access_ok & recall_i;
  assign acc_wr_o    = access_ok & ~recall_i & ~ce_ni & ~we_ni;
  assign drive_o     = access_ok & ~ce_ni & we_ni & ~oe_ni;
endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsb_ni,
  input  logic              store_go_i,
  input  logic              recall_go_i,
  input  logic              acc_wr_i,
  output nvs_state_e        state_o,
  output logic              dirty_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              store_step_o,
  output logic              recall_step_o
);
  localparam logic [ADDR_W-1:0] LastAddr = {ADDR_W{1'b1}};

  nvs_state_e        state_q;
  logic              dirty_q;
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= NVS_IDLE;
      dirty_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        NVS_IDLE: begin
          cnt_q <= '0;
          if (store_go_i) begin
            state_q <= dirty_q ? NVS_STORE : NVS_LOCK;
          end else if (recall_go_i) begin
            state_q <= NVS_RECALL;
          end else if (acc_wr_i) begin
            dirty_q <= 1'b1;
          end
        end
        NVS_STORE: begin
          if (cnt_q == LastAddr) begin
            state_q <= NVS_LOCK;
            dirty_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        NVS_RECALL: begin
          if (cnt_q == LastAddr) begin
            state_q <= NVS_IDLE;
            dirty_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        NVS_LOCK: begin
          if (hsb_ni) state_q <= NVS_IDLE;
        end
        default: state_q <= NVS_IDLE;
      endcase
    end
  end

  assign state_o       = state_q;
  assign dirty_o       = dirty_q;
  assign xfer_addr_o   = cnt_q;
  assign store_step_o  = (state_q == NVS_STORE);
  assign recall_step_o = (state_q == NVS_RECALL);
endmodule

// File: rtl/nvs_mem_array.sv
module nvs_mem_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_data_i,
  input  logic              store_step_i,
  input  logic              recall_step_i,
  input  logic [ADDR_W-1:0] xfer_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] sram_q   [Depth];
  logic [DATA_W-1:0] shadow_q [Depth];

  // access and recall are exclusive by state; access keeps priority anyway
  always_ff @(posedge clk_i) begin
    if (acc_wr_i) begin
      sram_q[acc_addr_i] <= acc_data_i;
    end else if (recall_step_i) begin
      sram_q[xfer_addr_i] <= shadow_q[xfer_addr_i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (store_step_i) shadow_q[xfer_addr_i] <= sram_q[xfer_addr_i];
  end

  assign rd_data_o = sram_q[acc_addr_i];
endmodule

// File: rtl/nvs_shadow_ctrl.sv
module nvs_shadow_ctrl
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              hsb_ni,
  input  logic              recall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  nvs_state_e        state_q;
  logic              dirty_q;
  logic              store_go, recall_go, acc_wr, drive;
  logic              store_step, recall_step;
  logic [ADDR_W-1:0] xfer_addr;
  logic [DATA_W-1:0] rd_data;

  nvs_mode_decode i_decode (
    .idle_i      (state_q == NVS_IDLE),
    .ce_ni       (ce_ni),
    .we_ni       (we_ni),
    .oe_ni       (oe_ni),
    .hsb_ni      (hsb_ni),
    .recall_i    (recall_i),
    .store_go_o  (store_go),
    .recall_go_o (recall_go),
    .acc_wr_o    (acc_wr),
    .drive_o     (drive)
  );

  nvs_xfer_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hsb_ni        (hsb_ni),
    .store_go_i    (store_go),
    .recall_go_i   (recall_go),
    .acc_wr_i      (acc_wr),
    .state_o       (state_q),
    .dirty_o       (dirty_q),
    .xfer_addr_o   (xfer_addr),
    .store_step_o  (store_step),
    .recall_step_o (recall_step)
  );

  nvs_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk_i         (clk_i),
    .acc_wr_i      (acc_wr),
    .acc_addr_i    (addr_i),
    .acc_data_i    (data_i),
    .store_step_i  (store_step),
    .recall_step_i (recall_step),
    .xfer_addr_i   (xfer_addr),
    .rd_data_o     (rd_data)
  );

  assign data_oe_o = drive;
  assign data_o    = drive ? rd_data : '0;
  assign busy_o    = (state_q != NVS_IDLE);
endmodule

// File: rtl/nvs_shadow_ctrl_chk.sv
module nvs_shadow_ctrl_chk
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       hsb_ni,
  input logic       busy_o,
  input logic       data_oe_o,
  input nvs_state_e state_i,
  input logic       dirty_i
);
  localparam int unsigned Depth = 1 << ADDR_W;

  int unsigned store_run_q;
  logic        was_recall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_run_q  <= 0;
      was_recall_q <= 1'b0;
    end else begin
      store_run_q  <= (state_i == NVS_STORE) ? store_run_q + 1 : 0;
      was_recall_q <= (state_i == NVS_RECALL);
    end
  end

  p_deselect_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o);

  p_strobe_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == NVS_IDLE && !hsb_ni) |=> busy_o);

  p_store_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != NVS_STORE && store_run_q != 0) |-> store_run_q == Depth);

  p_skip_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == NVS_IDLE && !hsb_ni && !dirty_i) |=> state_i == NVS_LOCK);

  p_lock_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == NVS_LOCK && !hsb_ni) |=> state_i == NVS_LOCK);

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == NVS_LOCK && hsb_ni) |=> !busy_o);

  p_recall_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (was_recall_q && state_i == NVS_IDLE) |-> !dirty_i);

  p_no_drive_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !data_oe_o);

  p_store_clean_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_run_q != 0 && state_i == NVS_LOCK) |-> !dirty_i);
endmodule

bind nvs_shadow_ctrl nvs_shadow_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .hsb_ni    (hsb_ni),
  .busy_o    (busy_o),
  .data_oe_o (data_oe_o),
  .state_i   (state_q),
  .dirty_i   (dirty_q)
);

// File: tb/test_nvs_shadow_ctrl.sv
`timescale 1ns/100ps
module test_nvs_shadow_ctrl;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b0, hsb_ni = 1'b1, recall_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              data_oe_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  nvs_shadow_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_nvs_shadow_ctrl (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .hsb_ni, .recall_i,
    .addr_i, .data_i, .data_o, .data_oe_o, .busy_o
  );

  // reference model: 0 idle, 1 store, 2 recall, 3 lock-out
  int         m_mode = 0;
  int         m_idx = 0;
  bit         m_dirty = 0;
  logic [7:0] m_sram   [DEPTH];
  logic [7:0] m_shadow [DEPTH];
  bit         m_known  [DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_idx = 0; m_dirty = 0;
    end else begin
      case (m_mode)
        0: begin
          m_idx = 0;
          if (!hsb_ni) m_mode = m_dirty ? 1 : 3;
          else if (recall_i) m_mode = 2;
          else if (!ce_ni && !we_ni) begin
            m_sram[addr_i] = data_i; m_known[addr_i] = 1; m_dirty = 1;
          end
        end
        1: begin
          m_shadow[m_idx] = m_sram[m_idx];
          if (m_idx == DEPTH-1) begin m_mode = 3; m_dirty = 0; end
          else m_idx++;
        end
        2: begin
          m_sram[m_idx] = m_shadow[m_idx];
          if (m_idx == DEPTH-1) begin m_mode = 0; m_dirty = 0; end
          else m_idx++;
        end
        default: if (hsb_ni) m_mode = 0;
      endcase
    end
  end

  // per-cycle comparison, late in the low phase
  always begin
    @(negedge clk_i);
    #1.5;
    if (rst_ni) begin
      bit exp_oe;
      exp_oe = (m_mode == 0) && hsb_ni && !ce_ni && we_ni && !oe_ni;
      chk(busy_o == (m_mode != 0), "R5 R6 R8 R9 busy", busy_o, m_mode != 0);
      chk(data_oe_o == exp_oe, "R1 R2 R3 R7 R11 drive", data_oe_o, exp_oe);
      if (exp_oe && m_known[addr_i])
        chk(data_o == m_sram[addr_i], "R2 R4 R9 data", data_o, m_sram[addr_i]);
    end
  end

  task automatic go_idle();
    ce_ni = 1; we_ni = 1; oe_ni = 0; hsb_ni = 1; recall_i = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    ce_ni = 0; we_ni = 0; addr_i = a[ADDR_W-1:0]; data_i = d[7:0];
    @(negedge clk_i);
    go_idle();
  endtask

  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk_i);
    ce_ni = 0; we_ni = 1; oe_ni = 0; addr_i = a[ADDR_W-1:0];
    #1;
    chk(data_oe_o == 1'b1, req, data_oe_o, 1);
    chk(data_o == exp[7:0], req, data_o, exp);
    @(negedge clk_i);
    go_idle();
  endtask

  // strobe low for `hold` cycles with junk writes to word 0; returns busy length
  task automatic strobe(input int hold, input bit junk, output int bc);
    bc = 0;
    @(negedge clk_i);
    hsb_ni = 0; oe_ni = 1;
    if (junk) begin ce_ni = 0; we_ni = 0; addr_i = '0; data_i = 8'hEE; end
    for (int i = 0; i < 4 * DEPTH; i++) begin
      @(negedge clk_i);
      #1;
      if (busy_o) bc++;
      if (i + 1 == hold) go_idle();
      if (!busy_o && i >= hold) break;
    end
    go_idle();
  endtask

  task automatic recall(output int bc);
    bc = 0;
    @(negedge clk_i);
    recall_i = 1; ce_ni = 0; we_ni = 0; addr_i = '0; data_i = 8'hEE;
    @(negedge clk_i);
    #1;
    if (busy_o) bc++;
    recall_i = 0;
    for (int i = 0; i < 4 * DEPTH; i++) begin
      @(negedge clk_i);
      #1;
      if (!busy_o) break;
      bc++;
    end
    go_idle();
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bc;
    for (int i = 0; i < DEPTH; i++) begin m_known[i] = 0; m_sram[i] = '0; m_shadow[i] = '0; end
    repeat (3) @(negedge clk_i);
    #1;
    chk(busy_o == 0, "R10 busy after reset", busy_o, 0);
    chk(data_oe_o == 0, "R10 drive after reset", data_oe_o, 0);
    rst_ni = 1;

    // R10: clean after reset, so a strobe is skipped
    strobe(2, 0, bc);
    chk(bc == 2, "R10 R6 skip after reset", bc, 2);

    // R4 R2: pattern A
    for (int i = 0; i < 8; i++) wr(i, 8'h11 * i + 8'h05);
    wr(DEPTH - 1, 8'hC3);
    for (int i = 0; i < 8; i++) rd(i, 8'h11 * i + 8'h05, "R2 R4 readback");
    rd(DEPTH - 1, 8'hC3, "R2 R4 top word");

    // R3: read with oe_ni high is not driven
    @(negedge clk_i);
    ce_ni = 0; we_ni = 1; oe_ni = 1; addr_i = 8'd3;
    #1;
    chk(data_oe_o == 0, "R3 oe gates drive", data_oe_o, 0);
    go_idle();

    // R1: deselected write strobe ignored
    @(negedge clk_i);
    ce_ni = 1; we_ni = 0; addr_i = 8'd2; data_i = 8'h99;
    #1;
    chk(data_oe_o == 0, "R1 deselected undriven", data_oe_o, 0);
    @(negedge clk_i);
    go_idle();
    rd(2, 8'h11 * 2 + 8'h05, "R1 no write when deselected");

    // R5 R7: real store with junk accesses
    strobe(3, 1, bc);
    chk(bc == DEPTH + 1, "R5 store busy length", bc, DEPTH + 1);
    rd(0, 8'h05, "R7 junk write ignored in store");

    // R12: store cleared the mark, long lock-out with junk
    strobe(7, 1, bc);
    chk(bc == 7, "R12 R6 skip after store", bc, 7);
    rd(0, 8'h05, "R7 junk write ignored in lock-out");

    // pattern B, then R9 recall restores A
    for (int i = 0; i < 8; i++) wr(i, 8'hF0 - i);
    rd(4, 8'hEC, "R4 overwrite");
    recall(bc);
    chk(bc == DEPTH, "R9 recall busy length", bc, DEPTH);
    for (int i = 0; i < 8; i++) rd(i, 8'h11 * i + 8'h05, "R9 recalled word");
    rd(DEPTH - 1, 8'hC3, "R9 recalled top word");

    // R9: recall leaves clean
    strobe(4, 0, bc);
    chk(bc == 4, "R9 R6 skip after recall", bc, 4);

    // R3: strobe starts with ce high and oe high
    wr(5, 8'h5A);
    @(negedge clk_i);
    ce_ni = 1; oe_ni = 1; hsb_ni = 0;
    @(negedge clk_i);
    #1;
    chk(busy_o == 1, "R3 R5 strobe not gated", busy_o, 1);
    go_idle();
    for (int i = 0; i < 4 * DEPTH; i++) begin
      @(negedge clk_i);
      #1;
      if (!busy_o) break;
    end
    chk(busy_o == 0, "R8 lock-out released", busy_o, 0);

    // strobe beats a simultaneous recall
    @(negedge clk_i);
    hsb_ni = 0; recall_i = 1;
    @(negedge clk_i);
    go_idle();
    @(negedge clk_i);
    #1;
    chk(busy_o == 0, "R6 strobe priority over recall", busy_o, 0);
    rd(5, 8'h5A, "R6 no recall ran");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule